// File: doc/BRIEF.md
# Charger Enable and Fault Supervisor

This block decides, once per clock, whether a switch-mode capacitor charger may run its power stage, and it drives the two open-drain indicator pins of the charger. It takes single-bit comparator flags that are already synchronized to its clock. It filters the slow or noisy flags through deglitch timers that have separate assert and release lengths. It then combines the filtered flags with the raw fast ones and a power-up hold-off into one charge-allowed signal.

While charging is allowed, the block ramps a current-reference code in eight equal steps to full scale. Any loss of permission returns the code to zero at once. All timer lengths are parameters counted in clock ticks. The defaults assume a 1 MHz clock, and a bench may shorten them. No stream of data passes through the block, so all its pins are plain level control and status signals with no handshake.

The power-good pin is low when the input supply is usable. The status pin is low (lit) while charging, released in sleep or lockout, and toggles while a condition that the user can act on holds the charger off.

Top module: `chg_supervisor`

## Requirements
- R1: `chg_allow_o` is 1 only if, one cycle earlier, `en_i`=1, `uvlo_i`=0, `vcc_low_i`=0, `reg_good_i`=1 and the filtered sleep, input-overvoltage, die-overheat and thermistor faults were all clear. Dropping any of the raw flags `en_i`, `uvlo_i`, `vcc_low_i` or `reg_good_i` clears `chg_allow_o` after the next clock edge.
- R2: After reset, and again after `uvlo_i` falls, `chg_allow_o` stays 0 for PWRUP_TICKS edges. It can first be 1 after edge PWRUP_TICKS+1.
- R3: Sleep is entered when `in_below_out_i` has been 1 for SLEEP_ENTER_TICKS consecutive edges, and it blocks charging. Sleep is left after SLEEP_EXIT_TICKS consecutive edges with the flag at 0.
- R4: `pg_n_o` (0 = power good) goes to 1 one edge after `in_below_out_i` has been 1 for PG_OFF_TICKS edges. It goes to 0 one edge after the flag has been 0 for PG_ON_TICKS edges. It is 0 only while `uvlo_i` was 0 and sleep was clear at the previous edge.
- R5: Input overvoltage blocks charging after `acov_i` has been 1 for ACOV_ON_TICKS edges. It releases after ACOV_OFF_TICKS edges at 0. A shorter pulse has no effect.
- R6: Die overheat blocks charging after TSHUT_ON_TICKS edges of `tshut_i`=1 and releases after TSHUT_OFF_TICKS edges at 0.
- R7: A thermistor fault blocks charging after TS_ON_TICKS edges of `ts_fault_i`=1 and releases after TS_OFF_TICKS edges at 0.
- R8: An edge at which `en_i` is sampled 0 after being 1 clears the overvoltage, overheat and thermistor fault states and their timers. A fault input still held at 1 must then be timed again in full.
- R9: `iref_code_o` is 0 while charging is not allowed. It becomes 1 one edge after `chg_allow_o` rises and then rises by exactly 1 every SS_STEP_TICKS edges until it holds at 8.
- R10: When `chg_allow_o` falls, `iref_code_o` is 0 one edge later, and the next start ramps again from 1.
- R11: `stat_n_o` (0 = lit) is 0 while charging. It is 1 in sleep, UVLO, VCC-low, regulator-bad, overheat or power-up hold-off. It toggles while not charging because `en_i` is 0, input overvoltage or a thermistor fault.
- R12: The toggle is a square wave of period BLINK_TICKS that is low for BLINK_TICKS/2 edges in every full period.
- R13: During reset `chg_allow_o`=0, `iref_code_o`=0, `pg_n_o`=1 and `stat_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Charge enable, 1 = enabled |
| uvlo_i | input | 1 | Input below lockout threshold |
| vcc_low_i | input | 1 | Input below low-voltage threshold |
| in_below_out_i | input | 1 | Input not above output voltage |
| acov_i | input | 1 | Input overvoltage comparator |
| reg_good_i | input | 1 | Internal regulators in range |
| tshut_i | input | 1 | Die over-temperature comparator |
| ts_fault_i | input | 1 | Thermistor out-of-window flag |
| chg_allow_o | output | 1 | Power stage may switch |
| iref_code_o | output | 4 | Soft-start current reference, 0..8 eighths |
| pg_n_o | output | 1 | Open-drain power good, 0 = pulled low |
| stat_n_o | output | 1 | Open-drain status, 0 = pulled low |

## Verification
Two functions meet in the same cycle when the enable falls while a thermistor fault is already latched. The falling enable clears the fault state, and the held fault input restarts its assert timer on the next edge. The bench pulses `en_i` low for one cycle under a held `ts_fault_i`. It expects `chg_allow_o` to return for exactly TS_ON_TICKS cycles and then drop again. A second meeting point is the loss of permission during the ramp against the ramp's own step. This is provoked with overvoltage and lockout during charging, and it is judged by a zero code one edge after the drop and a restart at 1.

// File: rtl/chg_sup_pkg.sv
`timescale 1ns/1ps
package chg_sup_pkg;
  localparam int unsigned SS_STEPS = 8;
  localparam int unsigned SS_W     = $clog2(SS_STEPS + 1);

  localparam int unsigned NUM_FLT   = 3;
  localparam int unsigned FLT_ACOV  = 0;
  localparam int unsigned FLT_TSHUT = 1;
  localparam int unsigned FLT_TS    = 2;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_BLINK = 2'd2
  } stat_mode_e;
endpackage

// File: rtl/chg_deglitch.sv
`timescale 1ns/1ps
// Asymmetric persistence filter: the output takes the input's level only
// after the input has differed from it for RISE_TICKS (0->1) or
// FALL_TICKS (1->0) consecutive edges.
module chg_deglitch #(
  parameter int unsigned RISE_TICKS = 1,
  parameter int unsigned FALL_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic raw_i,
  output logic q_o
);
  localparam int unsigned MAXT = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = q_o ? CW'(FALL_TICKS - 1) : CW'(RISE_TICKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o <= 1'b0;
      cnt <= '0;
    end else if (clr_i) begin
      q_o <= 1'b0;
      cnt <= '0;
    end else if (raw_i == q_o) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      q_o <= raw_i;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Shared by the sleep, power-good and fault filters (R3 to R7).
  assert_rise_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> ($past(cnt) == CW'(RISE_TICKS - 1)));
  assert_fall_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_o) |-> ($past(clr_i) || ($past(cnt) == CW'(FALL_TICKS - 1))));
endmodule

// File: rtl/chg_softstart.sv
`timescale 1ns/1ps
module chg_softstart import chg_sup_pkg::*; #(
  parameter int unsigned STEP_TICKS = 1600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  output logic [SS_W-1:0] code_o
);
  localparam int unsigned SC_W = $clog2(STEP_TICKS + 1);

  logic [SC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      code_o <= '0;
      cnt    <= '0;
    end else if (code_o == '0) begin
      code_o <= SS_W'(1);
      cnt    <= '0;
    end else if (code_o != SS_W'(SS_STEPS)) begin
      if (cnt == SC_W'(STEP_TICKS - 1)) begin
        code_o <= code_o + 1'b1;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_code_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_o <= SS_W'(SS_STEPS));
  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != $past(code_o)) |-> ((code_o == '0) || (code_o == SS_W'($past(code_o) + 1'b1))));
  assert_zero_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (code_o == '0));
endmodule

// File: rtl/chg_status.sv
`timescale 1ns/1ps
module chg_status import chg_sup_pkg::*; #(
  parameter int unsigned BLINK_TICKS = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  stat_mode_e mode_i,
  output logic       stat_n_o
);
  localparam int unsigned HALF = (BLINK_TICKS / 2 < 1) ? 1 : BLINK_TICKS / 2;
  localparam int unsigned BW   = $clog2(HALF + 1);

  logic [BW-1:0] cnt;
  logic          ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ph       <= 1'b0;
      stat_n_o <= 1'b1;
    end else begin
      if (mode_i != ST_BLINK) begin
        cnt <= '0;
        ph  <= 1'b0;
      end else if (cnt == BW'(HALF - 1)) begin
        cnt <= '0;
        ph  <= ~ph;
      end else begin
        cnt <= cnt + 1'b1;
      end
      case (mode_i)
        ST_ON:    stat_n_o <= 1'b0;
        ST_BLINK: stat_n_o <= ph;
        default:  stat_n_o <= 1'b1;
      endcase
    end
  end

  assert_phase_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != $past(ph)) |-> (($past(cnt) == BW'(HALF - 1)) || ($past(mode_i) != ST_BLINK)));
  assert_dark_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_n_o |-> ($past(mode_i) != ST_OFF));
endmodule

// File: rtl/chg_supervisor.sv
`timescale 1ns/1ps
module chg_supervisor import chg_sup_pkg::*; #(
  parameter int unsigned PWRUP_TICKS       = 30000,
  parameter int unsigned SLEEP_ENTER_TICKS = 100000,
  parameter int unsigned SLEEP_EXIT_TICKS  = 30000,
  parameter int unsigned PG_ON_TICKS       = 30000,
  parameter int unsigned PG_OFF_TICKS      = 1,
  parameter int unsigned ACOV_ON_TICKS     = 1000,
  parameter int unsigned ACOV_OFF_TICKS    = 1000,
  parameter int unsigned TSHUT_ON_TICKS    = 100,
  parameter int unsigned TSHUT_OFF_TICKS   = 10000,
  parameter int unsigned TS_ON_TICKS       = 400000,
  parameter int unsigned TS_OFF_TICKS      = 20000,
  parameter int unsigned SS_STEP_TICKS     = 1600,
  parameter int unsigned BLINK_TICKS       = 1000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            uvlo_i,
  input  logic            vcc_low_i,
  input  logic            in_below_out_i,
  input  logic            acov_i,
  input  logic            reg_good_i,
  input  logic            tshut_i,
  input  logic            ts_fault_i,
  output logic            chg_allow_o,
  output logic [SS_W-1:0] iref_code_o,
  output logic            pg_n_o,
  output logic            stat_n_o
);
  localparam int unsigned PWR_W = $clog2(PWRUP_TICKS + 1);
  localparam int unsigned FLT_RISE [NUM_FLT] = '{ACOV_ON_TICKS, TSHUT_ON_TICKS, TS_ON_TICKS};
  localparam int unsigned FLT_FALL [NUM_FLT] = '{ACOV_OFF_TICKS, TSHUT_OFF_TICKS, TS_OFF_TICKS};

  logic               en_d;
  logic               en_fall;
  logic               sleep_q;
  logic               src_good_q;
  logic [NUM_FLT-1:0] flt_raw;
  logic [NUM_FLT-1:0] flt_q;
  logic [PWR_W-1:0]   pwr_cnt;
  logic               pwr_ok;
  logic               allow_d;
  stat_mode_e         mode;

  assign en_fall = en_d & ~en_i;

  // Sleep: input at or below output, slow to enter, faster to leave.
  chg_deglitch #(.RISE_TICKS(SLEEP_ENTER_TICKS), .FALL_TICKS(SLEEP_EXIT_TICKS)) u_sleep (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .raw_i(in_below_out_i), .q_o(sleep_q));

  // Source-good for the power-good pin: fast drop, slow return.
  chg_deglitch #(.RISE_TICKS(PG_ON_TICKS), .FALL_TICKS(PG_OFF_TICKS)) u_src_good (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .raw_i(~in_below_out_i), .q_o(src_good_q));

  assign flt_raw[FLT_ACOV]  = acov_i;
  assign flt_raw[FLT_TSHUT] = tshut_i;
  assign flt_raw[FLT_TS]    = ts_fault_i;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    chg_deglitch #(.RISE_TICKS(FLT_RISE[g]), .FALL_TICKS(FLT_FALL[g])) u_flt (
      .clk(clk), .rst_n(rst_n), .clr_i(en_fall), .raw_i(flt_raw[g]), .q_o(flt_q[g]));
  end

  assign pwr_ok = (pwr_cnt == PWR_W'(PWRUP_TICKS));

  assign allow_d = en_i && !uvlo_i && !vcc_low_i && reg_good_i && !sleep_q
                && (flt_q == '0) && pwr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d        <= 1'b0;
      pwr_cnt     <= '0;
      chg_allow_o <= 1'b0;
      pg_n_o      <= 1'b1;
    end else begin
      en_d        <= en_i;
      chg_allow_o <= allow_d;
      pg_n_o      <= !(src_good_q && !uvlo_i && !sleep_q);
      if (uvlo_i)      pwr_cnt <= '0;
      else if (!pwr_ok) pwr_cnt <= pwr_cnt + 1'b1;
    end
  end

  always_comb begin
    if (uvlo_i || sleep_q)                               mode = ST_OFF;
    else if (chg_allow_o)                                mode = ST_ON;
    else if (!en_i || flt_q[FLT_ACOV] || flt_q[FLT_TS])  mode = ST_BLINK;
    else                                                 mode = ST_OFF;
  end

  chg_softstart #(.STEP_TICKS(SS_STEP_TICKS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run_i(chg_allow_o), .code_o(iref_code_o));

  chg_status #(.BLINK_TICKS(BLINK_TICKS)) u_stat (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .stat_n_o(stat_n_o));

  assert_allow_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chg_allow_o |-> $past(en_i && !uvlo_i && !vcc_low_i && reg_good_i));
  assert_pg_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n_o |-> $past(!uvlo_i));
  assert_no_ramp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iref_code_o != '0) |-> $past(chg_allow_o));
endmodule

// File: tb/tb_chg_supervisor.sv
`timescale 1ns/1ps
module tb_chg_supervisor;
  logic clk = 1'b0;
  logic rst_n;
  logic en, uvlo, vcc_low, below, acov, reg_good, tshut, ts;
  logic       allow;
  logic [3:0] code;
  logic       pg_n, stat_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string tag;
    int    sel;
    int    exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  event      chk_ev;

  always #10 clk = ~clk;

  chg_supervisor #(
    .PWRUP_TICKS(8), .SLEEP_ENTER_TICKS(12), .SLEEP_EXIT_TICKS(8),
    .PG_ON_TICKS(8), .PG_OFF_TICKS(2), .ACOV_ON_TICKS(5), .ACOV_OFF_TICKS(5),
    .TSHUT_ON_TICKS(3), .TSHUT_OFF_TICKS(9), .TS_ON_TICKS(10), .TS_OFF_TICKS(4),
    .SS_STEP_TICKS(4), .BLINK_TICKS(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_i(uvlo), .vcc_low_i(vcc_low),
    .in_below_out_i(below), .acov_i(acov), .reg_good_i(reg_good), .tshut_i(tshut),
    .ts_fault_i(ts), .chg_allow_o(allow), .iref_code_o(code), .pg_n_o(pg_n),
    .stat_n_o(stat_n));

  function automatic void check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  // sel: 0 allow, 1 code, 2 pg_n, 3 stat_n
  task automatic expect_out(string tag, int sel, int exp);
    exp_item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    -> chk_ev;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic blink_window(string tag, int exp_low);
    int lows = 0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (!stat_n) lows++;
    end
    check(tag, lows, exp_low);
  endtask

  // Monitor: pops expectations and compares just after the driver's negedge.
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (sb_q.size() > 0) begin
        exp_item_t it;
        int act;
        it = sb_q.pop_front();
        case (it.sel)
          0: act = int'(allow);
          1: act = int'(code);
          2: act = int'(pg_n);
          default: act = int'(stat_n);
        endcase
        check(it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; uvlo = 1'b0; vcc_low = 1'b0; below = 1'b0;
    acov = 1'b0; reg_good = 1'b1; tshut = 1'b0; ts = 1'b0;
    step(3);
    expect_out("R13 allow in reset", 0, 0);
    expect_out("R13 code in reset", 1, 0);
    expect_out("R13 pg_n in reset", 2, 1);
    expect_out("R13 stat_n in reset", 3, 1);
    rst_n = 1'b1;

    // Power-up hold-off and soft start
    step(8);
    expect_out("R2 held during power-up", 0, 0);
    expect_out("R4 pg still released", 2, 1);
    step(1);
    expect_out("R2 allowed after power-up", 0, 1);
    expect_out("R4 pg asserted", 2, 0);
    step(1);
    expect_out("R9 first ramp step", 1, 1);
    expect_out("R11 lit while charging", 3, 0);
    step(3);
    expect_out("R9 step held", 1, 1);
    step(1);
    expect_out("R9 second step", 1, 2);
    step(24);
    expect_out("R9 full scale", 1, 8);
    step(12);
    expect_out("R9 holds full scale", 1, 8);

    // Short overvoltage pulse ignored, then a sustained one
    acov = 1'b1; step(4); acov = 1'b0; step(4);
    expect_out("R5 short pulse ignored", 0, 1);
    expect_out("R5 short pulse code kept", 1, 8);
    acov = 1'b1;
    step(5);
    expect_out("R5 before assert window", 0, 1);
    step(1);
    expect_out("R5 blocked by overvoltage", 0, 0);
    step(1);
    expect_out("R10 code zeroed", 1, 0);
    step(2);
    blink_window("R12 overvoltage blink duty", 4);
    acov = 1'b0;
    step(5);
    expect_out("R5 still blocked in release window", 0, 0);
    step(1);
    expect_out("R5 released", 0, 1);
    step(1);
    expect_out("R10 ramp restarts at 1", 1, 1);

    // Die overheat: status dark, not blinking
    tshut = 1'b1;
    step(3);
    expect_out("R6 before assert window", 0, 1);
    step(1);
    expect_out("R6 blocked by overheat", 0, 0);
    step(2);
    blink_window("R11 dark during overheat", 0);
    tshut = 1'b0;
    step(9);
    expect_out("R6 still blocked in release window", 0, 0);
    step(1);
    expect_out("R6 released", 0, 1);

    // Thermistor fault, then enable pulse clears it
    ts = 1'b1;
    step(10);
    expect_out("R7 before assert window", 0, 1);
    step(1);
    expect_out("R7 blocked by thermistor", 0, 0);
    step(2);
    blink_window("R11 blink during thermistor fault", 4);
    en = 1'b0;
    step(1);
    expect_out("R8 enable low blocks", 0, 0);
    en = 1'b1;
    step(1);
    expect_out("R8 fault cleared by enable fall", 0, 1);
    step(9);
    expect_out("R8 fault retimed in full", 0, 1);
    step(1);
    expect_out("R7 fault reasserted", 0, 0);
    ts = 1'b0;
    step(4);
    expect_out("R7 still blocked in release window", 0, 0);
    step(1);
    expect_out("R7 released", 0, 1);

    // Sleep and power-good
    below = 1'b1;
    step(2);
    expect_out("R4 pg held within drop window", 2, 0);
    step(1);
    expect_out("R4 pg released", 2, 1);
    step(9);
    expect_out("R3 charging before sleep entry", 0, 1);
    step(1);
    expect_out("R3 sleep blocks charging", 0, 0);
    step(1);
    expect_out("R11 dark in sleep", 3, 1);
    below = 1'b0;
    step(8);
    expect_out("R3 sleep held in exit window", 0, 0);
    expect_out("R4 pg not yet asserted", 2, 1);
    step(1);
    expect_out("R3 sleep left", 0, 1);
    expect_out("R4 pg reasserted", 2, 0);

    // Lockout restarts the power-up hold-off
    uvlo = 1'b1;
    step(1);
    expect_out("R1 lockout blocks at once", 0, 0);
    expect_out("R4 pg released in lockout", 2, 1);
    step(1);
    expect_out("R10 code zero in lockout", 1, 0);
    expect_out("R11 dark in lockout", 3, 1);
    uvlo = 1'b0;
    step(1);
    expect_out("R4 pg back after lockout", 2, 0);
    step(7);
    expect_out("R2 hold-off after lockout", 0, 0);
    step(1);
    expect_out("R2 allowed after hold-off", 0, 1);

    // Raw gates
    vcc_low = 1'b1;
    step(1);
    expect_out("R1 vcc-low blocks", 0, 0);
    step(2);
    expect_out("R11 dark on vcc-low", 3, 1);
    vcc_low = 1'b0;
    step(1);
    expect_out("R1 vcc-low released", 0, 1);
    reg_good = 1'b0;
    step(1);
    expect_out("R1 regulator bad blocks", 0, 0);
    reg_good = 1'b1;
    step(1);
    expect_out("R1 regulator good resumes", 0, 1);

    // Enable low: blinking
    en = 1'b0;
    step(1);
    expect_out("R1 enable low blocks", 0, 0);
    step(2);
    blink_window("R12 enable-low blink duty", 4);
    expect_out("R9 code zero while disabled", 1, 0);

    step(2);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule